// File: doc/BRIEF.md
# Counting Sync-Flag Semaphore Bank

The bank holds a set of counting flags that a producer engine and a consumer engine share to pass permission rather than data. A producer raises a flag by adding to its count. A consumer either blocks until the count reaches a threshold it supplies, peeks at the count without blocking, or does an atomic add that returns the count held before the add. The flag space falls into three regions. The low global region is reachable from both the local port and a second port that serves the remote engine. The tile-scope and scalar-scope regions above it answer to the local port only.

A single waiter slot tracks one blocked wait at a time. A wait whose flag falls short of the threshold for a bounded number of cycles is aborted. The abort raises a sticky halt and records which waiter was stuck and on which flag. A signal request that names another partition is not applied locally; it is passed out on a forwarding port. An allocate request loads a run of flags with an initial state, either cleared to 0 or set to 1.

Top module: `sflagBank`

## Requirements
- R1: A local signal (locOp=0) whose partition field equals the own partition adds locOperand to the flag at locIdx, modulo 2^FlagW. The new count is visible one cycle later.
- R2: A local read (locOp=2) raises locRespValid one cycle later with locRespData holding the count from the request cycle. The count is left unchanged.
- R3: A local fetch-and-add (locOp=3) adds locOperand to the flag. One cycle later it returns the count held before the add, on locRespValid/locRespData.
- R4: A wait (locOp=1, locOperand = threshold) whose threshold is not yet met arms the waiter (waitBusy=1). One cycle after the first cycle in which the flag's count is at least the threshold, waitDone pulses with waitDoneTag equal to the request's locTag and waitBusy drops.
- R5: A wait whose threshold is already met when issued pulses waitDone one cycle later and never sets waitBusy.
- R6: If an armed wait is not met within TimeoutCycles cycles, waitAbort pulses and waitBusy drops. halt rises and stays high until reset, and haltTag/haltFlag latch the waiter's tag and flag index.
- R7: Flags 0..GlobalEnd-1 form the global region; GlobalEnd..TileEnd-1 form the tile region; TileEnd and above form the scalar region. A remote-port request (remOp 0 = signal, 1 = read) aimed above the global region has no effect. One cycle later it raises remErr, with remErrScalar=1 when the target was in the scalar region. A remote request into the global region is served, and a remote read answers on remRespValid/remRespData one cycle later.
- R8: A local add and a remote signal that hit the same flag in one cycle are both applied, so the flag advances by their sum.
- R9: A local signal whose locPart differs from OwnPart leaves every local flag unchanged. One cycle later it appears on fwdValid, with fwdPart/fwdIdx/fwdAmt carrying the partition, index and amount.
- R10: An allocate request (locOp=4) loads the flags from locIdx up to locIdx+count-1 with 1 if locOperand[15] is set, else 0. The count is locOperand[5:0]. Allocation overrides any increment to those flags in the same cycle.
- R11: A wait issued while waitBusy is high is rejected: locErr pulses one cycle later and the armed wait continues.
- R12: After reset every flag is 0 and halt, waitBusy, waitDone, waitAbort, locErr and remErr are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| locValid | input | 1 | Local request strobe |
| locOp | input | 3 | Local operation: 0 signal, 1 wait, 2 read, 3 fetch-add, 4 allocate |
| locIdx | input | IdxW | Flag index, or allocation base |
| locOperand | input | FlagW | Amount, threshold, or allocation control |
| locPart | input | PartW | Target partition of a signal |
| locTag | input | TagW | Waiter tag |
| locRespValid | output | 1 | Read / fetch-add response strobe |
| locRespData | output | FlagW | Count returned by a read or fetch-add |
| locErr | output | 1 | Wait rejected because the waiter was busy |
| waitBusy | output | 1 | A wait is armed |
| waitDone | output | 1 | Wait released pulse |
| waitDoneTag | output | TagW | Tag of the released wait |
| waitAbort | output | 1 | Wait timed out pulse |
| halt | output | 1 | Sticky halt after a timeout |
| haltTag | output | TagW | Tag of the timed-out waiter |
| haltFlag | output | IdxW | Flag the timed-out waiter watched |
| remValid | input | 1 | Remote request strobe |
| remOp | input | 1 | Remote operation: 0 signal, 1 read |
| remIdx | input | IdxW | Remote flag index |
| remOperand | input | FlagW | Remote signal amount |
| remRespValid | output | 1 | Remote read response strobe |
| remRespData | output | FlagW | Remote read count |
| remErr | output | 1 | Remote access outside the global region |
| remErrScalar | output | 1 | Rejected access was in the scalar region |
| fwdValid | output | 1 | Signal forwarded to another partition |
| fwdPart | output | PartW | Forwarded partition |
| fwdIdx | output | IdxW | Forwarded flag index |
| fwdAmt | output | FlagW | Forwarded amount |

## Verification
The bound checker watches the port-level cause and effect on every cycle. It checks that each remote access outside the global region draws remErr, and that remErr has no other cause. It also checks that halt never drops once raised, that release and abort never coincide, that responses only follow reads and fetch-adds, and that foreign-partition signals always reach the forwarding port. The actual counts cannot be shown that way, and only the bench's scenarios can show them. These are the wrap of an add, the old value returned by fetch-and-add, the summed same-cycle increments, allocation winning over a colliding increment, and the exact cycles of an immediate release, a late release and a timeout.

// File: rtl/sflagPkg.sv
package sflagPkg;

  typedef enum logic [2:0] {
    OpSignal   = 3'd0,
    OpWait     = 3'd1,
    OpRead     = 3'd2,
    OpFetchAdd = 3'd3,
    OpAlloc    = 3'd4
  } locOp_e;

  localparam logic RemSignal = 1'b0;
  localparam logic RemRead   = 1'b1;

  // strobes from control to datapath
  typedef struct packed {
    logic locAdd;
    logic remAdd;
    logic alloc;
    logic allocSet;
  } sflagStrb_t;

endpackage

// File: rtl/sflagDatapath.sv
module sflagDatapath
  import sflagPkg::*;
#(
  parameter int NumFlags = 32,
  parameter int FlagW    = 16,
  parameter int IdxW     = 5,
  parameter int CntW     = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  sflagStrb_t       strb,
  input  logic [IdxW-1:0]  locIdx,
  input  logic [FlagW-1:0] locAmt,
  input  logic [IdxW-1:0]  remIdx,
  input  logic [FlagW-1:0] remAmt,
  input  logic [IdxW-1:0]  allocBase,
  input  logic [CntW-1:0]  allocCount,
  output logic [FlagW-1:0] flagVal [NumFlags]
);

  localparam int SpanW = CntW + 1;

  logic [SpanW-1:0] allocLo, allocHi;
  assign allocLo = {2'b00, allocBase};
  assign allocHi = allocLo + {1'b0, allocCount};

  for (genvar i = 0; i < NumFlags; i++) begin : g_flag
    logic [FlagW-1:0] addLoc, addRem;
    logic             inAlloc;

    always_comb begin
      addLoc  = (strb.locAdd && locIdx == IdxW'(i)) ? locAmt : '0;
      addRem  = (strb.remAdd && remIdx == IdxW'(i)) ? remAmt : '0;
      inAlloc = strb.alloc && (SpanW'(i) >= allocLo) && (SpanW'(i) < allocHi);
    end

    always_ff @(posedge clk) begin
      if (!rstN)        flagVal[i] <= '0;
      else if (inAlloc) flagVal[i] <= strb.allocSet ? FlagW'(1) : '0;
      else              flagVal[i] <= flagVal[i] + addLoc + addRem;
    end
  end

endmodule

// File: rtl/sflagCtrl.sv
module sflagCtrl
  import sflagPkg::*;
#(
  parameter int NumFlags      = 32,
  parameter int FlagW         = 16,
  parameter int IdxW          = 5,
  parameter int CntW          = 6,
  parameter int PartW         = 2,
  parameter int TagW          = 4,
  parameter int GlobalEnd     = 16,
  parameter int TileEnd       = 24,
  parameter int OwnPart       = 0,
  parameter int TimeoutCycles = 1024
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             locValid,
  input  logic [2:0]       locOp,
  input  logic [IdxW-1:0]  locIdx,
  input  logic [FlagW-1:0] locOperand,
  input  logic [PartW-1:0] locPart,
  input  logic [TagW-1:0]  locTag,
  input  logic             remValid,
  input  logic             remOp,
  input  logic [IdxW-1:0]  remIdx,
  input  logic [FlagW-1:0] remOperand,
  input  logic [FlagW-1:0] flagVal [NumFlags],
  output sflagStrb_t       strb,
  output logic [IdxW-1:0]  dpLocIdx,
  output logic [FlagW-1:0] dpLocAmt,
  output logic [IdxW-1:0]  dpRemIdx,
  output logic [FlagW-1:0] dpRemAmt,
  output logic [CntW-1:0]  dpAllocCount,
  output logic             locRespValid,
  output logic [FlagW-1:0] locRespData,
  output logic             locErr,
  output logic             waitBusy,
  output logic             waitDone,
  output logic [TagW-1:0]  waitDoneTag,
  output logic             waitAbort,
  output logic             halt,
  output logic [TagW-1:0]  haltTag,
  output logic [IdxW-1:0]  haltFlag,
  output logic             remRespValid,
  output logic [FlagW-1:0] remRespData,
  output logic             remErr,
  output logic             remErrScalar,
  output logic             fwdValid,
  output logic [PartW-1:0] fwdPart,
  output logic [IdxW-1:0]  fwdIdx,
  output logic [FlagW-1:0] fwdAmt
);

  localparam int TmW = $clog2(TimeoutCycles + 1);
  localparam logic [TmW-1:0]   TmLast    = TmW'(TimeoutCycles - 1);
  localparam logic [IdxW:0]    GlobalLim = (IdxW+1)'(GlobalEnd);
  localparam logic [IdxW:0]    TileLim   = (IdxW+1)'(TileEnd);
  localparam logic [PartW-1:0] OwnPartL  = PartW'(OwnPart);

  logic             isSignal, isWait, isRead, isFetchAdd, isAlloc;
  logic             ownPart, remGlobal, waitMet;
  logic [FlagW-1:0] curVal, watchVal;

  logic [IdxW-1:0]  wIdx;
  logic [FlagW-1:0] wThr;
  logic [TagW-1:0]  wTag;
  logic [TmW-1:0]   tmCnt;

  always_comb begin
    isSignal   = locValid && locOp == OpSignal;
    isWait     = locValid && locOp == OpWait;
    isRead     = locValid && locOp == OpRead;
    isFetchAdd = locValid && locOp == OpFetchAdd;
    isAlloc    = locValid && locOp == OpAlloc;
    ownPart    = locPart == OwnPartL;
    remGlobal  = {1'b0, remIdx} < GlobalLim;
    curVal     = flagVal[locIdx];
    watchVal   = flagVal[wIdx];
    waitMet    = waitBusy && (watchVal >= wThr);

    strb.locAdd   = (isSignal && ownPart) || isFetchAdd;
    strb.remAdd   = remValid && remOp == RemSignal && remGlobal;
    strb.alloc    = isAlloc;
    strb.allocSet = locOperand[FlagW-1];

    dpLocIdx     = locIdx;
    dpLocAmt     = locOperand;
    dpRemIdx     = remIdx;
    dpRemAmt     = remOperand;
    dpAllocCount = locOperand[CntW-1:0];
  end

  // response, error and forwarding registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      locRespValid <= 1'b0;
      locRespData  <= '0;
      locErr       <= 1'b0;
      remRespValid <= 1'b0;
      remRespData  <= '0;
      remErr       <= 1'b0;
      remErrScalar <= 1'b0;
      fwdValid     <= 1'b0;
      fwdPart      <= '0;
      fwdIdx       <= '0;
      fwdAmt       <= '0;
    end else begin
      locRespValid <= isRead || isFetchAdd;
      locRespData  <= curVal;
      locErr       <= isWait && waitBusy;
      remRespValid <= remValid && remOp == RemRead && remGlobal;
      remRespData  <= flagVal[remIdx];
      remErr       <= remValid && !remGlobal;
      remErrScalar <= remValid && ({1'b0, remIdx} >= TileLim);
      fwdValid     <= isSignal && !ownPart;
      fwdPart      <= locPart;
      fwdIdx       <= locIdx;
      fwdAmt       <= locOperand;
    end
  end

  // single waiter slot with timeout
  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitBusy    <= 1'b0;
      waitDone    <= 1'b0;
      waitDoneTag <= '0;
      waitAbort   <= 1'b0;
      halt        <= 1'b0;
      haltTag     <= '0;
      haltFlag    <= '0;
      wIdx        <= '0;
      wThr        <= '0;
      wTag        <= '0;
      tmCnt       <= '0;
    end else begin
      waitDone  <= 1'b0;
      waitAbort <= 1'b0;
      if (waitBusy) begin
        if (waitMet) begin
          waitBusy    <= 1'b0;
          waitDone    <= 1'b1;
          waitDoneTag <= wTag;
        end else if (tmCnt == TmLast) begin
          waitBusy  <= 1'b0;
          waitAbort <= 1'b1;
          halt      <= 1'b1;
          haltTag   <= wTag;
          haltFlag  <= wIdx;
        end else begin
          tmCnt <= tmCnt + 1'b1;
        end
      end else if (isWait) begin
        if (curVal >= locOperand) begin
          waitDone    <= 1'b1;
          waitDoneTag <= locTag;
        end else begin
          waitBusy <= 1'b1;
          wIdx     <= locIdx;
          wThr     <= locOperand;
          wTag     <= locTag;
          tmCnt    <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/sflagBank.sv
module sflagBank
  import sflagPkg::*;
#(
  parameter int NumFlags      = 32,
  parameter int FlagW         = 16,
  parameter int PartW         = 2,
  parameter int TagW          = 4,
  parameter int GlobalEnd     = 16,
  parameter int TileEnd       = 24,
  parameter int OwnPart       = 0,
  parameter int TimeoutCycles = 1024,
  localparam int IdxW         = $clog2(NumFlags),
  localparam int CntW         = IdxW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             locValid,
  input  logic [2:0]       locOp,
  input  logic [IdxW-1:0]  locIdx,
  input  logic [FlagW-1:0] locOperand,
  input  logic [PartW-1:0] locPart,
  input  logic [TagW-1:0]  locTag,
  output logic             locRespValid,
  output logic [FlagW-1:0] locRespData,
  output logic             locErr,
  output logic             waitBusy,
  output logic             waitDone,
  output logic [TagW-1:0]  waitDoneTag,
  output logic             waitAbort,
  output logic             halt,
  output logic [TagW-1:0]  haltTag,
  output logic [IdxW-1:0]  haltFlag,
  input  logic             remValid,
  input  logic             remOp,
  input  logic [IdxW-1:0]  remIdx,
  input  logic [FlagW-1:0] remOperand,
  output logic             remRespValid,
  output logic [FlagW-1:0] remRespData,
  output logic             remErr,
  output logic             remErrScalar,
  output logic             fwdValid,
  output logic [PartW-1:0] fwdPart,
  output logic [IdxW-1:0]  fwdIdx,
  output logic [FlagW-1:0] fwdAmt
);

  sflagStrb_t       strb;
  logic [FlagW-1:0] flagVal [NumFlags];
  logic [IdxW-1:0]  dpLocIdx, dpRemIdx;
  logic [FlagW-1:0] dpLocAmt, dpRemAmt;
  logic [CntW-1:0]  dpAllocCount;

  sflagCtrl #(
    .NumFlags(NumFlags), .FlagW(FlagW), .IdxW(IdxW), .CntW(CntW),
    .PartW(PartW), .TagW(TagW), .GlobalEnd(GlobalEnd), .TileEnd(TileEnd),
    .OwnPart(OwnPart), .TimeoutCycles(TimeoutCycles)
  ) ctrl_i (
    .clk, .rstN, .locValid, .locOp, .locIdx, .locOperand, .locPart, .locTag,
    .remValid, .remOp, .remIdx, .remOperand, .flagVal, .strb,
    .dpLocIdx, .dpLocAmt, .dpRemIdx, .dpRemAmt, .dpAllocCount,
    .locRespValid, .locRespData, .locErr, .waitBusy, .waitDone, .waitDoneTag,
    .waitAbort, .halt, .haltTag, .haltFlag, .remRespValid, .remRespData,
    .remErr, .remErrScalar, .fwdValid, .fwdPart, .fwdIdx, .fwdAmt
  );

  sflagDatapath #(
    .NumFlags(NumFlags), .FlagW(FlagW), .IdxW(IdxW), .CntW(CntW)
  ) dp_i (
    .clk, .rstN, .strb,
    .locIdx(dpLocIdx), .locAmt(dpLocAmt),
    .remIdx(dpRemIdx), .remAmt(dpRemAmt),
    .allocBase(dpLocIdx), .allocCount(dpAllocCount),
    .flagVal
  );

endmodule

// File: rtl/sflagBankChk.sv
module sflagBankChk #(
  parameter int IdxW      = 5,
  parameter int PartW     = 2,
  parameter int GlobalEnd = 16,
  parameter int OwnPart   = 0
) (
  input logic             clk,
  input logic             rstN,
  input logic             locValid,
  input logic [2:0]       locOp,
  input logic [PartW-1:0] locPart,
  input logic             locRespValid,
  input logic             waitDone,
  input logic             waitAbort,
  input logic             halt,
  input logic             remValid,
  input logic [IdxW-1:0]  remIdx,
  input logic             remErr,
  input logic             fwdValid
);

  localparam logic [IdxW:0]    GlobalLim = (IdxW+1)'(GlobalEnd);
  localparam logic [PartW-1:0] OwnPartL  = PartW'(OwnPart);

  logic remOutside, foreignSig, respCause;
  assign remOutside = remValid && ({1'b0, remIdx} >= GlobalLim);
  assign foreignSig = locValid && locOp == 3'd0 && locPart != OwnPartL;
  assign respCause  = locValid && (locOp == 3'd2 || locOp == 3'd3);

  // R7
  remote_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    remOutside |=> remErr);

  // R7
  rem_err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    remErr |-> $past(remOutside));

  // R6
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    halt |=> halt);

  // R4
  done_abort_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(waitDone && waitAbort));

  // R9
  forward_chk: assert property (@(posedge clk) disable iff (!rstN)
    foreignSig |=> fwdValid);

  // R2
  resp_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    locRespValid |-> $past(respCause));

endmodule

bind sflagBank sflagBankChk #(
  .IdxW(IdxW), .PartW(PartW), .GlobalEnd(GlobalEnd), .OwnPart(OwnPart)
) chk_i (
  .clk(clk), .rstN(rstN), .locValid(locValid), .locOp(locOp), .locPart(locPart),
  .locRespValid(locRespValid), .waitDone(waitDone), .waitAbort(waitAbort),
  .halt(halt), .remValid(remValid), .remIdx(remIdx), .remErr(remErr),
  .fwdValid(fwdValid)
);

// File: tb/sflagBank_tb.sv
module sflagBank_tb_top;

  localparam int ClkPeriod = 10;
  localparam int TimeoutT  = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        locValid = 1'b0;
  logic [2:0]  locOp = '0;
  logic [4:0]  locIdx = '0;
  logic [15:0] locOperand = '0;
  logic [1:0]  locPart = '0;
  logic [3:0]  locTag = '0;
  logic        locRespValid, locErr, waitBusy, waitDone, waitAbort, halt;
  logic [15:0] locRespData, remRespData, fwdAmt;
  logic [3:0]  waitDoneTag, haltTag;
  logic [4:0]  haltFlag, fwdIdx;
  logic        remValid = 1'b0;
  logic        remOp = 1'b0;
  logic [4:0]  remIdx = '0;
  logic [15:0] remOperand = '0;
  logic        remRespValid, remErr, remErrScalar, fwdValid;
  logic [1:0]  fwdPart;

  int nChk = 0;
  int nErr = 0;

  always #(ClkPeriod/2) clk = ~clk;

  sflagBank #(.TimeoutCycles(TimeoutT)) dut_i (
    .clk, .rstN, .locValid, .locOp, .locIdx, .locOperand, .locPart, .locTag,
    .locRespValid, .locRespData, .locErr, .waitBusy, .waitDone, .waitDoneTag,
    .waitAbort, .halt, .haltTag, .haltFlag, .remValid, .remOp, .remIdx,
    .remOperand, .remRespValid, .remRespData, .remErr, .remErrScalar,
    .fwdValid, .fwdPart, .fwdIdx, .fwdAmt
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // drives one request for one clock, returns at the next falling edge
  task automatic issue(logic lv, logic [2:0] op, logic [4:0] idx, logic [15:0] opd,
                       logic [1:0] part, logic [3:0] tag,
                       logic rv, logic rop, logic [4:0] ridx, logic [15:0] ropd);
    locValid = lv; locOp = op; locIdx = idx; locOperand = opd; locPart = part; locTag = tag;
    remValid = rv; remOp = rop; remIdx = ridx; remOperand = ropd;
    cyc();
    locValid = 1'b0; remValid = 1'b0;
  endtask

  task automatic loc(logic [2:0] op, logic [4:0] idx, logic [15:0] opd, logic [3:0] tag);
    issue(1'b1, op, idx, opd, 2'd0, tag, 1'b0, 1'b0, 5'd0, 16'd0);
  endtask

  task automatic rem(logic rop, logic [4:0] ridx, logic [15:0] ropd);
    issue(1'b0, 3'd0, 5'd0, 16'd0, 2'd0, 4'd0, 1'b1, rop, ridx, ropd);
  endtask

  task automatic readChk(string req, logic [4:0] idx, logic [15:0] exp);
    loc(3'd2, idx, 16'd0, 4'd0);
    chk(req, "read valid", 32'(locRespValid), 32'd1);
    chk(req, "read data", 32'(locRespData), 32'(exp));
  endtask

  // {req 4, op 3, idx 5, operand 16, expected 16}
  localparam int NumVec = 10;
  localparam logic [43:0] Vecs [NumVec] = '{
    {4'd1, 3'd0, 5'd0,  16'd5,      16'd0},
    {4'd2, 3'd2, 5'd0,  16'd0,      16'd5},
    {4'd3, 3'd3, 5'd0,  16'd3,      16'd5},
    {4'd3, 3'd2, 5'd0,  16'd0,      16'd8},
    {4'd1, 3'd0, 5'd1,  16'hFFFF,   16'd0},
    {4'd1, 3'd0, 5'd1,  16'd2,      16'd0},
    {4'd1, 3'd2, 5'd1,  16'd0,      16'd1},
    {4'd3, 3'd3, 5'd17, 16'd4,      16'd0},
    {4'd2, 3'd2, 5'd17, 16'd0,      16'd4},
    {4'd2, 3'd2, 5'd24, 16'd0,      16'd0}
  };

  function automatic string reqName(logic [3:0] r);
    case (r)
      4'd1:    return "R1";
      4'd2:    return "R2";
      default: return "R3";
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin : stim
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();

    // R12 reset state
    chk("R12", "halt", 32'(halt), 32'd0);
    chk("R12", "waitBusy", 32'(waitBusy), 32'd0);
    chk("R12", "waitDone", 32'(waitDone), 32'd0);
    chk("R12", "remErr", 32'(remErr), 32'd0);
    readChk("R12", 5'd31, 16'd0);

    // table walk: R1 R2 R3
    for (int v = 0; v < NumVec; v++) begin
      logic [43:0] e = Vecs[v];
      loc(e[39:37], e[36:32], e[31:16], 4'd0);
      if (e[39:37] == 3'd2 || e[39:37] == 3'd3) begin
        chk(reqName(e[43:40]), $sformatf("vec %0d valid", v), 32'(locRespValid), 32'd1);
        chk(reqName(e[43:40]), $sformatf("vec %0d data", v), 32'(locRespData), 32'(e[15:0]));
      end
    end

    // R7 region rejection on the remote port
    rem(1'b0, 5'd20, 16'd9);
    chk("R7", "tile remErr", 32'(remErr), 32'd1);
    chk("R7", "tile scalar bit", 32'(remErrScalar), 32'd0);
    rem(1'b0, 5'd28, 16'd9);
    chk("R7", "scalar remErr", 32'(remErr), 32'd1);
    chk("R7", "scalar bit", 32'(remErrScalar), 32'd1);
    readChk("R7", 5'd20, 16'd0);
    readChk("R7", 5'd28, 16'd0);
    rem(1'b0, 5'd2, 16'd1);
    chk("R7", "global no err", 32'(remErr), 32'd0);
    rem(1'b1, 5'd2, 16'd0);
    chk("R7", "remote read valid", 32'(remRespValid), 32'd1);
    chk("R7", "remote read data", 32'(remRespData), 32'd1);

    // R8 same-cycle local and remote increments
    issue(1'b1, 3'd0, 5'd2, 16'd3, 2'd0, 4'd0, 1'b1, 1'b0, 5'd2, 16'd4);
    readChk("R8", 5'd2, 16'd8);

    // R9 foreign partition forwarded
    issue(1'b1, 3'd0, 5'd6, 16'd7, 2'd1, 4'd0, 1'b0, 1'b0, 5'd0, 16'd0);
    chk("R9", "fwdValid", 32'(fwdValid), 32'd1);
    chk("R9", "fwdPart", 32'(fwdPart), 32'd1);
    chk("R9", "fwdIdx", 32'(fwdIdx), 32'd6);
    chk("R9", "fwdAmt", 32'(fwdAmt), 32'd7);
    readChk("R9", 5'd6, 16'd0);

    // R10 allocation, set state, with a colliding remote increment
    issue(1'b1, 3'd4, 5'd4, 16'h8003, 2'd0, 4'd0, 1'b1, 1'b0, 5'd5, 16'd9);
    readChk("R10", 5'd4, 16'd1);
    readChk("R10", 5'd5, 16'd1);
    readChk("R10", 5'd6, 16'd1);
    readChk("R10", 5'd7, 16'd0);
    loc(3'd4, 5'd4, 16'h0001, 4'd0);
    readChk("R10", 5'd4, 16'd0);
    readChk("R10", 5'd5, 16'd1);

    // R5 threshold already met
    loc(3'd1, 5'd2, 16'd8, 4'd3);
    chk("R5", "waitDone", 32'(waitDone), 32'd1);
    chk("R5", "tag", 32'(waitDoneTag), 32'd3);
    chk("R5", "waitBusy", 32'(waitBusy), 32'd0);

    // R4 blocked wait released by increments
    loc(3'd1, 5'd2, 16'd10, 4'd5);
    chk("R4", "armed busy", 32'(waitBusy), 32'd1);
    chk("R4", "not done", 32'(waitDone), 32'd0);
    // R11 second wait rejected
    loc(3'd1, 5'd3, 16'd1, 4'd7);
    chk("R11", "locErr", 32'(locErr), 32'd1);
    chk("R11", "still busy", 32'(waitBusy), 32'd1);
    rem(1'b0, 5'd2, 16'd1);
    chk("R4", "below threshold", 32'(waitDone), 32'd0);
    loc(3'd0, 5'd2, 16'd1, 4'd0);
    chk("R4", "reached this edge", 32'(waitDone), 32'd0);
    cyc();
    chk("R4", "released", 32'(waitDone), 32'd1);
    chk("R4", "release tag", 32'(waitDoneTag), 32'd5);
    chk("R4", "busy cleared", 32'(waitBusy), 32'd0);
    chk("R4", "no halt", 32'(halt), 32'd0);

    // R6 timeout abort
    loc(3'd1, 5'd9, 16'd1, 4'd6);
    repeat (TimeoutT - 1) cyc();
    chk("R6", "halt before limit", 32'(halt), 32'd0);
    cyc();
    chk("R6", "halt", 32'(halt), 32'd1);
    chk("R6", "waitAbort", 32'(waitAbort), 32'd1);
    chk("R6", "haltTag", 32'(haltTag), 32'd6);
    chk("R6", "haltFlag", 32'(haltFlag), 32'd9);
    chk("R6", "busy cleared", 32'(waitBusy), 32'd0);
    cyc();
    chk("R6", "halt sticky", 32'(halt), 32'd1);

    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

endmodule